// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits behind a CAN receiver. When a frame has been fully received into the background buffer, it decides whether the host should be told about the frame. Frames the host is not told about are simply overwritten by the next reception. The decision compares the identifier bytes with programmable code bytes, one bit at a time. Mask bits let selected positions be excluded from the comparison. Extended-identifier frames are matched over all four identifier bytes. Standard-identifier frames are matched over the first two bytes only.

Two independent filter banks are provided, and a frame is accepted when either bank matches. An accepted frame produces a one-cycle accept pulse, together with the index of the bank that hit. It also sets a sticky received flag that the host clears. The code and mask bytes sit behind a byte-wide register port. They can be read at any time, but a write only takes effect while both the init-request and init-acknowledge inputs are high.

Top module: `can_id_filter`

## Requirements
- R1: After reset, every code and mask byte reads 0x00, and `accept_o`, `hit_idx_o` and `rx_flag_o` are 0.
- R2: For an extended frame (`ext_i`=1), a bank matches when, for all 32 bits, either the mask bit is 1 or the identifier bit equals the code bit. Identifier byte n is `id_i[31-8n -: 8]` and is compared with code byte n and mask byte n of the bank.
- R3: For a standard frame (`ext_i`=0), only identifier bytes 0 and 1 (`id_i[31:16]`) take part, against code and mask bytes 0 and 1. Bytes 2 and 3 have no effect on the result.
- R4: A mask bit of 1 makes its position don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R5: A frame is accepted when any bank matches. `hit_idx_o` gives the lowest-numbered matching bank, and is 0 whenever `accept_o` is 0.
- R6: `accept_o` is high for exactly the one cycle that follows a cycle in which `frame_done_i` was sampled high with a matching frame. Without a strobe it stays 0, whatever the identifier inputs are.
- R7: A write to a code or mask byte takes effect only when `init_req_i` and `init_ack_i` are both 1. Otherwise the byte keeps its value.
- R8: `reg_rdata_o` combinationally shows the byte at `reg_addr_i` in any mode. Addresses above the flag address read 0x00.
- R9: `rx_flag_o` is set by an accept and stays set. It is cleared by a write, in any mode, of a value with bit 0 = 1 to the flag address 8*NUM_BANKS, whose read value is {7'b0, flag}. Writing 0 has no effect, and a set in the same cycle as a clear wins.
- R10: Code byte n of bank b is at address 8b+n, and mask byte n of bank b is at address 8b+4+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_req_i | input | 1 | Initialization request state |
| init_ack_i | input | 1 | Initialization acknowledge state |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data at `reg_addr_i` |
| id_i | input | 32 | Identifier bytes 0..3 of the buffered frame, byte 0 in the top bits |
| ext_i | input | 1 | 1 = extended identifier, 0 = standard |
| frame_done_i | input | 1 | Frame-complete strobe |
| accept_o | output | 1 | One-cycle accept pulse |
| hit_idx_o | output | IDX_W | Index of the matching bank |
| rx_flag_o | output | 1 | Sticky received flag |

## Verification
The bench builds the block with its default of two banks, which gives a 5-bit address space with the flag at address 16. With two banks, a frame can be made to match both banks at once, so the lowest-index priority can be observed. The spare addresses 17 to 31 exercise the read-as-zero decode. The bank contents are chosen so that some identifiers pass as standard frames but fail as extended frames, which shows the frame-type dependent width.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int ID_BYTES    = 4;
  localparam int STD_BYTES   = 2;
  localparam int BANK_STRIDE = 2 * ID_BYTES;
  localparam int ID_W        = 8 * ID_BYTES;

  typedef logic [7:0]      byte_t;
  typedef logic [ID_W-1:0] id_word_t;
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_open_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  byte_t                           wdata_i,
  input  logic                            flag_set_i,
  output byte_t                           rdata_o,
  output logic [NUM_BANKS-1:0][ID_W-1:0]  code_o,
  output logic [NUM_BANKS-1:0][ID_W-1:0]  mask_o,
  output logic                            flag_o
);
  localparam int FLAG_ADDR = int'(NUM_BANKS) * BANK_STRIDE;

  byte_t code_q [NUM_BANKS][ID_BYTES];
  byte_t mask_q [NUM_BANKS][ID_BYTES];
  logic  flag_q;
  logic  flag_hit;

  assign flag_hit = (addr_i == ADDR_W'(FLAG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
        for (int n = 0; n < ID_BYTES; n++) begin
          code_q[b][n] <= '0;
          mask_q[b][n] <= '0;
        end
      end
    end else if (we_i && cfg_open_i) begin
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
        for (int n = 0; n < ID_BYTES; n++) begin
          if (addr_i == ADDR_W'(b * BANK_STRIDE + n))
            code_q[b][n] <= wdata_i;
          if (addr_i == ADDR_W'(b * BANK_STRIDE + ID_BYTES + n))
            mask_q[b][n] <= wdata_i;
        end
      end
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             flag_q <= 1'b0;
    else if (flag_set_i)                     flag_q <= 1'b1;
    else if (we_i && flag_hit && wdata_i[0]) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      for (int n = 0; n < ID_BYTES; n++) begin
        if (addr_i == ADDR_W'(b * BANK_STRIDE + n))
          rdata_o = code_q[b][n];
        if (addr_i == ADDR_W'(b * BANK_STRIDE + ID_BYTES + n))
          rdata_o = mask_q[b][n];
      end
    end
    if (flag_hit) rdata_o = {7'b0, flag_q};
  end

  // byte n lands in the top-down byte lane n of the word
  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    for (genvar n = 0; n < ID_BYTES; n++) begin : g_byte
      assign code_o[b][8*(ID_BYTES-1-n) +: 8] = code_q[b][n];
      assign mask_o[b][8*(ID_BYTES-1-n) +: 8] = mask_q[b][n];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
  import can_flt_pkg::*;
(
  input  id_word_t code_i,
  input  id_word_t mask_i,
  input  id_word_t id_i,
  input  logic     ext_i,
  output logic     hit_o
);
  id_word_t bit_ok;
  logic [ID_BYTES-1:0] byte_ok;

  assign bit_ok = ~(id_i ^ code_i) | mask_i;

  for (genvar n = 0; n < ID_BYTES; n++) begin : g_lane
    if (n < STD_BYTES) begin : g_always
      assign byte_ok[n] = &bit_ok[8*(ID_BYTES-1-n) +: 8];
    end else begin : g_ext_only
      assign byte_ok[n] = ~ext_i | (&bit_ok[8*(ID_BYTES-1-n) +: 8]);
    end
  end

  assign hit_o = &byte_ok;
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0] hit_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int b = int'(NUM_BANKS) - 1; b >= 0; b--) begin
      if (hit_i[b]) idx_o = IDX_W'(b);
    end
  end

  assign any_o = |hit_i;
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_flt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned ADDR_W = $clog2(NUM_BANKS * BANK_STRIDE + 1),
  localparam int unsigned IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_req_i,
  input  logic              init_ack_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [ID_W-1:0]   id_i,
  input  logic              ext_i,
  input  logic              frame_done_i,
  output logic              accept_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic              rx_flag_o
);
  logic [NUM_BANKS-1:0][ID_W-1:0] code_w, mask_w;
  logic [NUM_BANKS-1:0]           bank_hit;
  logic                           any_hit;
  logic [IDX_W-1:0]               win_idx;
  logic                           take;
  logic                           accept_q;
  logic [IDX_W-1:0]               idx_q;

  assign take = frame_done_i & any_hit;

  can_flt_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_open_i (init_req_i & init_ack_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flag_set_i (take),
    .rdata_o    (reg_rdata_o),
    .code_o     (code_w),
    .mask_o     (mask_w),
    .flag_o     (rx_flag_o)
  );

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    can_flt_match u_match (
      .code_i (code_w[b]),
      .mask_i (mask_w[b]),
      .id_i   (id_i),
      .ext_i  (ext_i),
      .hit_o  (bank_hit[b])
    );
  end

  can_flt_prio #(.NUM_BANKS(NUM_BANKS)) u_prio (
    .hit_i (bank_hit),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      accept_q <= take;
      idx_q    <= take ? win_idx : '0;
    end
  end

  assign accept_o  = accept_q;
  assign hit_idx_o = idx_q;
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk
  import can_flt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned IDX_W     = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_req_i,
  input logic              init_ack_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic [ID_W-1:0]   id_i,
  input logic              ext_i,
  input logic              frame_done_i,
  input logic              accept_o,
  input logic [IDX_W-1:0]  hit_idx_o,
  input logic              rx_flag_o
);
  localparam int FLAG_ADDR = int'(NUM_BANKS) * BANK_STRIDE;

  a_r6_accept_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(frame_done_i));

  a_r5_idx_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (hit_idx_o == '0));

  a_r9_flag_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> rx_flag_o);

  a_r9_flag_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_flag_o) |-> accept_o);

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flag_o && !(reg_we_i && reg_addr_i == ADDR_W'(FLAG_ADDR) && reg_wdata_i[0]))
    |=> rx_flag_o);

  a_r7_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !(init_req_i && init_ack_i) && reg_addr_i < ADDR_W'(FLAG_ADDR))
    ##1 (reg_addr_i == $past(reg_addr_i)) |-> $stable(reg_rdata_o));
endmodule

bind can_id_filter can_id_filter_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W)
) chk_i (.*);

// File: tb/can_id_filter_tb_top.sv
`timescale 1ns/1ps
module can_id_filter_tb_top;
  localparam int NV = 12;
  // {ext, id[31:0], accept, hit_idx}
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 32'h12345678, 1'b1, 1'b0},
    {1'b1, 32'h123456FF, 1'b1, 1'b0},
    {1'b1, 32'h12345778, 1'b0, 1'b0},
    {1'b1, 32'hABC12345, 1'b1, 1'b1},
    {1'b1, 32'hACCD0000, 1'b0, 1'b0},
    {1'b0, 32'h1234FFFF, 1'b1, 1'b0},
    {1'b1, 32'h1234FFFF, 1'b0, 1'b0},
    {1'b0, 32'hABC00000, 1'b1, 1'b1},
    {1'b0, 32'h13340000, 1'b0, 1'b0},
    {1'b1, 32'h12345600, 1'b1, 1'b0},
    {1'b1, 32'hAB0D1234, 1'b0, 1'b0},
    {1'b0, 32'hAB3D9999, 1'b0, 1'b0}
  };

  logic       clk = 0, rst_n = 0;
  logic       init_req = 0, init_ack = 0, we = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [31:0] id = '0;
  logic       ext = 0, fdone = 0;
  logic       accept, hit_idx, rx_flag;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_id_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .init_ack_i(init_ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .id_i(id), .ext_i(ext), .frame_done_i(fdone),
    .accept_o(accept), .hit_idx_o(hit_idx), .rx_flag_o(rx_flag)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_check(string tag, logic [4:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  // strobe one frame, check pulse, then flag, then clear flag
  task automatic frame(string tag, logic e, logic [31:0] v, logic acc, logic hi);
    @(negedge clk); ext = e; id = v; fdone = 1;
    @(negedge clk); fdone = 0;
    check({tag, " accept"}, accept, acc);
    check({tag, " hit_idx"}, hit_idx, hi);
    check({tag, " flag"}, rx_flag, acc);
    @(negedge clk);
    check({tag, " R6 pulse end"}, {accept, hit_idx}, 0);
    wr(5'd16, 8'h01);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 accept", accept, 0);
    check("R1 flag", rx_flag, 0);
    for (int a = 0; a < 16; a++) rd_check("R1 regs zero", 5'(a), 8'h00);

    // R10 program map in init mode
    init_req = 1; init_ack = 1;
    wr(5'd0, 8'h12); wr(5'd1, 8'h34); wr(5'd2, 8'h56); wr(5'd3, 8'h78);
    wr(5'd4, 8'h00); wr(5'd5, 8'h00); wr(5'd6, 8'h00); wr(5'd7, 8'hFF);
    wr(5'd8, 8'hAB); wr(5'd9, 8'hCD); wr(5'd10, 8'h00); wr(5'd11, 8'h00);
    wr(5'd12, 8'h00); wr(5'd13, 8'h0F); wr(5'd14, 8'hFF); wr(5'd15, 8'hFF);
    rd_check("R10 bank0 code byte2", 5'd2, 8'h56);
    rd_check("R10 bank1 mask byte1", 5'd13, 8'h0F);
    init_req = 0; init_ack = 0;

    // R2/R3/R4/R5 vector table
    for (int k = 0; k < NV; k++)
      frame($sformatf("R2/R3/R4/R5 vec%0d", k), VEC[k][34], VEC[k][33:2],
            VEC[k][1], VEC[k][0]);

    // R6 no accept without strobe
    @(negedge clk); ext = 1; id = 32'h12345678;
    repeat (3) begin
      @(negedge clk);
      check("R6 no strobe", accept, 0);
    end

    // R7 gated writes
    init_req = 1; init_ack = 0;
    wr(5'd0, 8'h55);
    rd_check("R7 req only", 5'd0, 8'h12);
    init_req = 0; init_ack = 1;
    wr(5'd4, 8'hFF);
    rd_check("R7 ack only", 5'd4, 8'h00);
    init_req = 0; init_ack = 0;
    frame("R7 filter unchanged", 1'b1, 32'h12345678, 1'b1, 1'b0);

    // R8 reads outside init mode, out of range
    rd_check("R8 read anytime", 5'd8, 8'hAB);
    rd_check("R8 addr 17", 5'd17, 8'h00);
    rd_check("R8 addr 31", 5'd31, 8'h00);

    // R5 priority when both banks match
    init_req = 1; init_ack = 1;
    for (int a = 4; a < 8; a++) wr(5'(a), 8'hFF);
    init_req = 0; init_ack = 0;
    frame("R5 both banks", 1'b1, 32'hABC12345, 1'b1, 1'b0);

    // R9 sticky flag, ignored zero write, W1C, set wins
    @(negedge clk); id = 32'h0; ext = 1; fdone = 1;
    @(negedge clk); fdone = 0;
    repeat (3) @(negedge clk);
    check("R9 sticky", rx_flag, 1);
    rd_check("R9 flag read", 5'd16, 8'h01);
    wr(5'd16, 8'h00);
    check("R9 zero write no effect", rx_flag, 1);
    wr(5'd16, 8'h01);
    check("R9 w1c", rx_flag, 0);
    @(negedge clk); fdone = 1; we = 1; addr = 5'd16; wdata = 8'h01;
    @(negedge clk); fdone = 0; we = 0;
    check("R9 set wins", rx_flag, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule